// File: doc/BRIEF.md
# Masked Status Condition Evaluator

A DMA channel's command sequencer makes three decisions when a command finishes: whether to raise an interrupt, whether to branch to another command, and whether to stall and wait. All three use the same rule, so this block evaluates them side by side. Each decision has a 32-bit select word that holds a 4-bit mask and a 4-bit compare value. The decision's condition is true when the low four device status bits, after masking, equal the masked compare value. A 2-bit mode field taken from the current command word then resolves the decision: never act, act on the condition, act on its inverse, or always act.

The sequencer raises `eval_i` for one cycle, or for several back-to-back cycles, while the status, select words and command word are valid. At the next clock edge the block registers the three outcomes. The interrupt request appears as a one-cycle pulse. The branch and wait flags are levels that keep their value until the next strobe. The block does not store the select words or the status, and it does not handle descriptors.

Top module: `cond_eval_unit`

## Requirements
- R1: In every select word the mask is bits 19:16 and the compare value is bits 3:0. All other bits of the select word have no effect on any output.
- R2: The condition is true exactly when (status[3:0] AND mask) equals (value AND mask). Status bits 7:4 have no effect.
- R3: The mode encoding is 0 = never act, 1 = act when the condition is true, 2 = act when the condition is false, 3 = always act. The same encoding applies to all three decisions.
- R4: In modes 0 and 3 the outcome does not depend on the select word or on the status.
- R5: A mask of zero makes the condition true, so mode 1 always acts and mode 2 never acts.
- R6: The interrupt decision uses `irq_sel_i` and command bits 5:4. The branch decision uses `br_sel_i` and command bits 3:2. The wait decision uses `wait_sel_i` and command bits 1:0. Command bits 15:6 have no effect.
- R7: `irq_pulse_o` is high for the one cycle that follows a clock edge at which `eval_i` was high and the interrupt decision acted. It is low in every other cycle.
- R8: `take_branch_o` and `must_wait_o` take the outcome registered at the clock edge where `eval_i` is high. They hold that value through every edge at which `eval_i` is low.
- R9: While `rst_n` is low all three outputs are low, and they stay low after reset is released until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eval_i | input | 1 | Evaluate strobe from the sequencer |
| dev_status_i | input | 8 | Device status bits of the channel status word |
| irq_sel_i | input | 32 | Interrupt select word (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select word (mask 19:16, value 3:0) |
| wait_sel_i | input | 32 | Wait select word (mask 19:16, value 3:0) |
| cmd_i | input | 16 | Command word; bits 5:4 interrupt mode, 3:2 branch mode, 1:0 wait mode |
| irq_pulse_o | output | 1 | One-cycle interrupt request |
| take_branch_o | output | 1 | Branch decision, held between strobes |
| must_wait_o | output | 1 | Wait decision, held between strobes |

## Verification
An interrupt and a branch can be decided on the same strobe, and each one reads its own select word and its own slice of the command. A crossed select word or a crossed slice would therefore only be visible when the two lanes disagree. The exhaustive sweep gives each lane a different mode and a permuted mask/value pair on every strobe, with the strobes back to back, so a separate expected outcome is computed and compared for each lane in every cycle. The random phase mixes strobe gaps with input changes, which shows whether a held level or a pulse leaks into a cycle where no evaluation took place.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  typedef enum logic [1:0] {
    ACT_NEVER    = 2'd0,
    ACT_IF_MATCH = 2'd1,
    ACT_IF_MISS  = 2'd2,
    ACT_ALWAYS   = 2'd3
  } act_mode_e;

  // Resolve a decision from its mode and the masked condition.
  function automatic logic resolve_act(input act_mode_e mode, input logic hit);
    logic r;
    case (mode)
      ACT_NEVER:    r = 1'b0;
      ACT_IF_MATCH: r = hit;
      ACT_IF_MISS:  r = ~hit;
      default:      r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cond_match.sv
module cond_match #(
  parameter int COND_W = 4
) (
  input  logic [COND_W-1:0] status_i,
  input  logic [COND_W-1:0] mask_i,
  input  logic [COND_W-1:0] value_i,
  output logic              hit_o
);

  function automatic logic masked_equal(input logic [COND_W-1:0] s,
                                        input logic [COND_W-1:0] m,
                                        input logic [COND_W-1:0] v);
    return (s & m) == (v & m);
  endfunction

  assign hit_o = masked_equal(status_i, mask_i, value_i);

endmodule

// File: rtl/cond_lane.sv
module cond_lane
  import cond_eval_pkg::*;
#(
  parameter int SEL_W    = 32,
  parameter int COND_W   = 4,
  parameter int MASK_LSB = 16,
  parameter int MODE_W   = 2
) (
  input  logic [COND_W-1:0] status_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              hit_o,
  output logic              act_o
);

  localparam int MASK_MSB = MASK_LSB + COND_W - 1;

  logic [COND_W-1:0] mask_w;
  logic [COND_W-1:0] value_w;

  assign mask_w  = sel_i[MASK_MSB:MASK_LSB];
  assign value_w = sel_i[COND_W-1:0];

  wire unused_sel_bits = ^{sel_i[SEL_W-1:MASK_MSB+1], sel_i[MASK_LSB-1:COND_W]};

  cond_match #(.COND_W(COND_W)) u_match (
    .status_i (status_i),
    .mask_i   (mask_w),
    .value_i  (value_w),
    .hit_o    (hit_o)
  );

  assign act_o = resolve_act(act_mode_e'(mode_i), hit_o);

endmodule

// File: rtl/cond_out_stage.sv
module cond_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eval_i,
  input  logic [2:0] act_i,
  output logic       irq_pulse_o,
  output logic       take_branch_o,
  output logic       must_wait_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse_o   <= 1'b0;
      take_branch_o <= 1'b0;
      must_wait_o   <= 1'b0;
    end else begin
      irq_pulse_o <= eval_i & act_i[0];
      if (eval_i) begin
        take_branch_o <= act_i[1];
        must_wait_o   <= act_i[2];
      end
    end
  end

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit #(
  parameter int SEL_W    = 32,
  parameter int STAT_W   = 8,
  parameter int COND_W   = 4,
  parameter int MASK_LSB = 16,
  parameter int CMD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [STAT_W-1:0] dev_status_i,
  input  logic [SEL_W-1:0]  irq_sel_i,
  input  logic [SEL_W-1:0]  br_sel_i,
  input  logic [SEL_W-1:0]  wait_sel_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              irq_pulse_o,
  output logic              take_branch_o,
  output logic              must_wait_o
);

  localparam int NUM_DEC = 3;
  localparam int MODE_W  = 2;
  localparam int MODES_W = NUM_DEC * MODE_W;

  logic [SEL_W-1:0]   sel_arr [NUM_DEC];
  logic [NUM_DEC-1:0] lane_hit;
  logic [NUM_DEC-1:0] lane_act;

  // lane 0 interrupt, lane 1 branch, lane 2 wait
  assign sel_arr[0] = irq_sel_i;
  assign sel_arr[1] = br_sel_i;
  assign sel_arr[2] = wait_sel_i;

  wire unused_hi_bits = ^{dev_status_i[STAT_W-1:COND_W], cmd_i[CMD_W-1:MODES_W]};

  generate
    for (genvar g = 0; g < NUM_DEC; g++) begin : g_lane
      cond_lane #(
        .SEL_W    (SEL_W),
        .COND_W   (COND_W),
        .MASK_LSB (MASK_LSB),
        .MODE_W   (MODE_W)
      ) u_lane (
        .status_i (dev_status_i[COND_W-1:0]),
        .sel_i    (sel_arr[g]),
        .mode_i   (cmd_i[MODE_W*(NUM_DEC-1-g) +: MODE_W]),
        .hit_o    (lane_hit[g]),
        .act_o    (lane_act[g])
      );
    end
  endgenerate

  cond_out_stage u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .eval_i        (eval_i),
    .act_i         (lane_act),
    .irq_pulse_o   (irq_pulse_o),
    .take_branch_o (take_branch_o),
    .must_wait_o   (must_wait_o)
  );

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
  parameter int SEL_W = 32,
  parameter int CMD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eval_i,
  input logic [CMD_W-1:0] cmd_i,
  input logic [SEL_W-1:0] br_sel_i,
  input logic [2:0]       lane_hit,
  input logic             irq_pulse_o,
  input logic             take_branch_o,
  input logic             must_wait_o
);

  // R7
  irq_only_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> $past(eval_i));

  // R8
  hold_between_evals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> ($stable(take_branch_o) && $stable(must_wait_o)));

  // R3
  irq_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_i[5:4] == 2'd0) |=> !irq_pulse_o);

  // R3
  branch_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_i[3:2] == 2'd3) |=> take_branch_o);

  // R2
  wait_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_i[1:0] == 2'd1) |=> (must_wait_o == $past(lane_hit[2])));

  // R4
  wait_mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_i[1:0] == 2'd0) |=> !must_wait_o);

  // R5
  zero_mask_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && br_sel_i[19:16] == 4'd0 && cmd_i[3:2] == 2'd2) |=> !take_branch_o);

endmodule

bind cond_eval_unit cond_eval_chk #(.SEL_W(SEL_W), .CMD_W(CMD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .eval_i        (eval_i),
  .cmd_i         (cmd_i),
  .br_sel_i      (br_sel_i),
  .lane_hit      (lane_hit),
  .irq_pulse_o   (irq_pulse_o),
  .take_branch_o (take_branch_o),
  .must_wait_o   (must_wait_o)
);

// File: tb/cond_eval_unit_tb_top.sv
module cond_eval_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        eval_i;
  logic [7:0]  dev_status_i;
  logic [31:0] irq_sel_i, br_sel_i, wait_sel_i;
  logic [15:0] cmd_i;
  logic        irq_pulse_o, take_branch_o, must_wait_o;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;
  logic exp_irq = 1'b0, exp_br = 1'b0, exp_wt = 1'b0;

  always #2 clk = ~clk;

  cond_eval_unit dut_i (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .dev_status_i(dev_status_i),
    .irq_sel_i(irq_sel_i), .br_sel_i(br_sel_i), .wait_sel_i(wait_sel_i),
    .cmd_i(cmd_i), .irq_pulse_o(irq_pulse_o), .take_branch_o(take_branch_o),
    .must_wait_o(must_wait_o)
  );

  // condition: the status and the value agree on every bit the mask selects
  function automatic bit cond_ref(input logic [7:0] st, input logic [31:0] sel);
    return (((st[3:0] ^ sel[3:0]) & sel[19:16]) == 4'h0);
  endfunction

  function automatic bit act_ref(input logic [1:0] md, input bit c);
    if (md == 2'd3) return 1'b1;
    if (md == 2'd0) return 1'b0;
    return (md == 2'd1) ? c : !c;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Check the outputs of the previous step, then drive the next one.
  task automatic step(input bit ev, input logic [7:0] st, input logic [31:0] is,
                      input logic [31:0] bs, input logic [31:0] ws,
                      input logic [15:0] cmd, input string tag);
    @(negedge clk);
    chk({tag, " R6 R7 irq"}, irq_pulse_o, exp_irq);
    chk({tag, " R6 R8 branch"}, take_branch_o, exp_br);
    chk({tag, " R6 R8 wait"}, must_wait_o, exp_wt);
    eval_i = ev; dev_status_i = st; irq_sel_i = is; br_sel_i = bs;
    wait_sel_i = ws; cmd_i = cmd;
    exp_irq = ev && act_ref(cmd[5:4], cond_ref(st, is));
    if (ev) begin
      exp_br = act_ref(cmd[3:2], cond_ref(st, bs));
      exp_wt = act_ref(cmd[1:0], cond_ref(st, ws));
    end
  endtask

  function automatic logic [31:0] pack_sel(input logic [3:0] m, input logic [3:0] v);
    logic [31:0] r;
    r = $urandom;
    r[19:16] = m;
    r[3:0]   = v;
    return r;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd9137));
    rst_n = 1'b0; eval_i = 1'b1; dev_status_i = 8'hFF;
    irq_sel_i = '0; br_sel_i = '0; wait_sel_i = '0; cmd_i = 16'h003F;
    // R9: always-act modes and a strobe held high during reset
    repeat (3) begin
      @(negedge clk);
      chk("R9 reset irq", irq_pulse_o, 1'b0);
      chk("R9 reset branch", take_branch_o, 1'b0);
      chk("R9 reset wait", must_wait_o, 1'b0);
    end
    eval_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 8'hFF, '1, '1, '1, 16'hFFFF, "R9 idle after reset");

    // R1 R5: mask field zero, other bits set; mode 1 acts, mode 2 does not
    step(1'b1, 8'h5A, 32'hFFF0_FFF3, 32'hFFF0_FFF5, 32'hFFF0_FFFC, 16'hFF16, "R1 R5 zero mask");
    step(1'b1, 8'hA5, 32'hFFF0_FFF1, 32'hFFF0_FFF2, 32'hFFF0_FFF9, 16'h0026, "R5 zero mask inv");
    // R4: modes 0 and 3 with conflicting select words
    step(1'b1, 8'h00, 32'h000F_0001, 32'h000F_000F, 32'h000F_0001, 16'h0030, "R4 modes 0 3");
    step(1'b1, 8'h0F, 32'h000F_0000, 32'h000F_000F, 32'h000F_0000, 16'h000C, "R4 modes 3 0");
    // R2: upper status bits ignored
    step(1'b1, 8'hF3, 32'h0003_0003, 32'h0003_0003, 32'h0003_0003, 16'h0015, "R2 upper status");
    step(1'b0, 8'h00, '0, '0, '0, 16'h0000, "R8 hold");
    step(1'b0, 8'hFF, '1, '1, '1, 16'h002A, "R8 hold");

    // R2 R3 R6: exhaustive sweep, lanes given different modes and operands
    for (int i = 0; i < 16384; i++) begin
      logic [3:0] m, v, s;
      logic [1:0] md;
      m = i[3:0]; v = i[7:4]; s = i[11:8]; md = i[13:12];
      step(1'b1, {4'($urandom), s}, pack_sel(m, v), pack_sel(v, m), pack_sel(m, ~v),
           {10'($urandom), md, md + 2'd1, md + 2'd2}, "R2 R3 sweep");
    end

    // R7 R8: random strobes with gaps and changing inputs
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, 8'($urandom), $urandom, $urandom, $urandom,
           16'($urandom), "R8 random");
    end
    step(1'b0, 8'h00, '0, '0, '0, 16'h0000, "R7 final");
    step(1'b0, 8'h00, '0, '0, '0, 16'h0000, "R7 final");
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

endmodule